// File: doc/BRIEF.md
# Prescaled 64-bit Compare Timer

This block is a memory-mapped machine timer for one hart. A 64-bit time count advances by a programmable step once every programmable number of clock cycles. A single 64-bit compare value is checked against it. The block has two outputs. One is a raw pending level that follows the compare result and takes no account of the enable bit. The other is an interrupt request, gated by the enable bit, that comes from a latched status bit. Software can clear that status bit, and a test register can force it.

Access is through a plain 32-bit register port. The `regAddr` port carries a word address, which is the byte offset divided by four. A write happens on every clock edge where `regWe` is high. Read data is combinational from `regAddr`. While the active flag is clear, both the count and the compare evaluation stand still.

Top module: `tct_timer`

## Requirements
- R1: After reset, all of these are zero: control, configuration, the count, the prescale counter, the enable bit and the status bit. Both compare halves are all ones. `timerPending` and `irqOut` are low.
- R2: The active flag is bit 0 at byte offset 0x00. While it is 0, the count and the prescale counter hold their values. While it is 0, the pending level and the status bit are not re-evaluated.
- R3: The configuration register is at byte offset 0x100. The prescale value is in bits 11:0 and the step value is in bits 23:16. Every other bit reads as zero.
- R4: While active, the prescale counter counts up by one each cycle. In the cycle where it has reached or passed the prescale value, it returns to 0 and the count adds the zero-extended step. The count wraps modulo 2^64.
- R5: The count's low and high halves are at byte offsets 0x104 and 0x108. The compare value's low and high halves are at 0x10C and 0x110, with the high register as bits 63:32. Each of these registers is readable and writable. A write to a count half replaces that half on the next edge, and the count is not incremented in that cycle.
- R6: On each active edge the pending level is reloaded with the unsigned test compare <= count, using the register values held before that edge. A register write therefore shows on `timerPending` one edge later. A compare value that is already in the past expires at once.
- R7: The status bit is bit 0 at byte offset 0x118, and the enable bit is bit 0 at byte offset 0x114. An active evaluation that finds expiry sets the status bit only if the enable bit is 1. `irqOut` is the status bit ANDed with the enable bit.
- R8: An active evaluation that finds no expiry clears both the pending level and the status bit.
- R9: Writing 1 to status bit 0 clears the status bit, and writing 0 has no effect. If a clear and a hardware set fall in the same cycle, the set wins.
- R10: Writing 1 to bit 0 at byte offset 0x11C sets the status bit. Writing 0 there has no effect. That register always reads as zero.
- R11: Reads of unmapped offsets return zero, and writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Write strobe, one write per high cycle |
| regAddr | input | 8 | Word address (byte offset / 4) |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational read data |
| timerPending | output | 1 | Raw expiry level, not gated by the enable bit |
| irqOut | output | 1 | Interrupt request: status AND enable |

## Verification
A software write of 1 to the status bit can arrive on the same edge as a hardware evaluation that finds the timer expired with the enable bit set. The bench provokes this by issuing the clear while a compare value that is already in the past stays in place. After that edge it expects the status bit to read back as 1 and `irqOut` to stay high. A second case writes the compare value ahead of the count while the timer is counting. That write races the evaluation on the following edge, and the bench expects the status bit and `timerPending` to fall exactly one edge after the write. It judges this against a behavioural model that is compared on every clock.

// File: rtl/tct_pkg.sv
package tct_pkg;
  parameter int DATA_W   = 32;
  parameter int PRE_W    = 12;
  parameter int STEP_W   = 8;
  parameter int STEP_LSB = 16;
  localparam int CNT_W   = 2 * DATA_W;

  // word addresses (byte offset / 4)
  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_CFG   = 'h40;
  localparam int OFF_CNTLO = 'h41;
  localparam int OFF_CNTHI = 'h42;
  localparam int OFF_CMPLO = 'h43;
  localparam int OFF_CMPHI = 'h44;
  localparam int OFF_IEN   = 'h45;
  localparam int OFF_IST   = 'h46;
  localparam int OFF_TEST  = 'h47;

  typedef struct packed {
    logic              active;
    logic [PRE_W-1:0]  prescale;
    logic [STEP_W-1:0] step;
    logic              enable;
    logic              wrCntLo;
    logic              wrCntHi;
    logic              wrCmpLo;
    logic              wrCmpHi;
    logic              clrState;
    logic              setTest;
    logic [DATA_W-1:0] wdata;
  } strobes_t;
endpackage

// File: rtl/tct_ctrl.sv
module tct_ctrl
  import tct_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [CNT_W-1:0]  cmpVal,
  input  logic              stateBit,
  output strobes_t          strb,
  output logic [DATA_W-1:0] regRdata
);
  logic              activeQ;
  logic [PRE_W-1:0]  prescaleQ;
  logic [STEP_W-1:0] stepQ;
  logic              enableQ;

  logic selCtrl, selCfg, selCntLo, selCntHi, selCmpLo, selCmpHi;
  logic selIen, selIst, selTest;

  always_comb begin
    selCtrl  = (regAddr == ADDR_W'(OFF_CTRL));
    selCfg   = (regAddr == ADDR_W'(OFF_CFG));
    selCntLo = (regAddr == ADDR_W'(OFF_CNTLO));
    selCntHi = (regAddr == ADDR_W'(OFF_CNTHI));
    selCmpLo = (regAddr == ADDR_W'(OFF_CMPLO));
    selCmpHi = (regAddr == ADDR_W'(OFF_CMPHI));
    selIen   = (regAddr == ADDR_W'(OFF_IEN));
    selIst   = (regAddr == ADDR_W'(OFF_IST));
    selTest  = (regAddr == ADDR_W'(OFF_TEST));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ   <= 1'b0;
      prescaleQ <= '0;
      stepQ     <= '0;
      enableQ   <= 1'b0;
    end else if (regWe) begin
      if (selCtrl) activeQ <= regWdata[0];
      if (selCfg) begin
        prescaleQ <= regWdata[PRE_W-1:0];
        stepQ     <= regWdata[STEP_LSB +: STEP_W];
      end
      if (selIen) enableQ <= regWdata[0];
    end
  end

  always_comb begin
    strb.active   = activeQ;
    strb.prescale = prescaleQ;
    strb.step     = stepQ;
    strb.enable   = enableQ;
    strb.wrCntLo  = regWe && selCntLo;
    strb.wrCntHi  = regWe && selCntHi;
    strb.wrCmpLo  = regWe && selCmpLo;
    strb.wrCmpHi  = regWe && selCmpHi;
    strb.clrState = regWe && selIst && regWdata[0];
    strb.setTest  = regWe && selTest && regWdata[0];
    strb.wdata    = regWdata;
  end

  always_comb begin
    regRdata = '0;
    unique case (1'b1)
      selCtrl:  regRdata[0] = activeQ;
      selCfg: begin
        regRdata[PRE_W-1:0]         = prescaleQ;
        regRdata[STEP_LSB +: STEP_W] = stepQ;
      end
      selCntLo: regRdata = cntVal[DATA_W-1:0];
      selCntHi: regRdata = cntVal[CNT_W-1:DATA_W];
      selCmpLo: regRdata = cmpVal[DATA_W-1:0];
      selCmpHi: regRdata = cmpVal[CNT_W-1:DATA_W];
      selIen:   regRdata[0] = enableQ;
      selIst:   regRdata[0] = stateBit;
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/tct_datapath.sv
module tct_datapath
  import tct_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strb,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] cmpVal,
  output logic             expired,
  output logic             stateBit
);
  logic [PRE_W-1:0] preCnt;
  logic             tick;
  logic             hit;

  assign tick = strb.active && (preCnt >= strb.prescale);
  assign hit  = (cmpVal <= cntVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (strb.active) begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (strb.wrCntLo) begin
      cntVal <= {cntVal[CNT_W-1:DATA_W], strb.wdata};
    end else if (strb.wrCntHi) begin
      cntVal <= {strb.wdata, cntVal[DATA_W-1:0]};
    end else if (tick) begin
      cntVal <= cntVal + CNT_W'(strb.step);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpVal <= '1;
    end else if (strb.wrCmpLo) begin
      cmpVal <= {cmpVal[CNT_W-1:DATA_W], strb.wdata};
    end else if (strb.wrCmpHi) begin
      cmpVal <= {strb.wdata, cmpVal[DATA_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expired <= 1'b0;
    end else if (strb.active) begin
      expired <= hit;
    end
  end

  // priority: test set, hardware set, software clear, evaluation clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateBit <= 1'b0;
    end else if (strb.setTest) begin
      stateBit <= 1'b1;
    end else if (strb.active && hit && strb.enable) begin
      stateBit <= 1'b1;
    end else if (strb.clrState) begin
      stateBit <= 1'b0;
    end else if (strb.active && !hit) begin
      stateBit <= 1'b0;
    end
  end
endmodule

// File: rtl/tct_timer.sv
module tct_timer
  import tct_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              timerPending,
  output logic              irqOut
);
  strobes_t         strb;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] cmpVal;
  logic             stateBit;

  tct_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .cntVal(cntVal), .cmpVal(cmpVal),
    .stateBit(stateBit), .strb(strb), .regRdata(regRdata)
  );

  tct_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cntVal(cntVal),
    .cmpVal(cmpVal), .expired(timerPending), .stateBit(stateBit)
  );

  assign irqOut = stateBit && strb.enable;
endmodule

// File: rtl/tct_checker.sv
module tct_checker
  import tct_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regRdata,
  input logic              timerPending,
  input strobes_t          strb,
  input logic [CNT_W-1:0]  cntVal,
  input logic              stateBit
);
  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.active && !strb.wrCntLo && !strb.wrCntHi) |=> $stable(cntVal));

  // R4
  step_add_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.wrCntLo) && !$past(strb.wrCntHi) && (cntVal != $past(cntVal)))
      |-> (cntVal == $past(cntVal) + CNT_W'($past(strb.step))));

  // R6
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timerPending) |-> $past(strb.active));

  // R7
  state_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stateBit) |-> ($past(strb.enable) || $past(strb.setTest)));

  // R3
  cfg_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(OFF_CFG)) |->
      (regRdata[DATA_W-1:STEP_LSB+STEP_W] == '0 && regRdata[STEP_LSB-1:PRE_W] == '0));

  // R10
  test_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(OFF_TEST)) |-> (regRdata == '0));
endmodule

bind tct_timer tct_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRdata(regRdata),
  .timerPending(timerPending), .strb(strb), .cntVal(cntVal),
  .stateBit(stateBit)
);

// File: tb/sim_tct_timer.sv
`timescale 1ns/1ps
module sim_tct_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = 8'h0;
  logic [31:0] regWdata = 32'h0;
  logic [31:0] regRdata;
  logic        timerPending, irqOut;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  tct_timer u0 (.clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .timerPending(timerPending),
    .irqOut(irqOut));

  // behavioural reference
  bit          mAct, mEn, mSt, mExp;
  int unsigned mPre, mStep, mPc;
  longint unsigned mCnt, mCmp;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAct <= 0; mEn <= 0; mSt <= 0; mExp <= 0;
      mPre <= 0; mStep <= 0; mPc <= 0; mCnt <= 0; mCmp <= '1;
    end else begin
      bit w, hit, wrap;
      w = regWe;
      hit = (mCmp <= mCnt);
      wrap = mAct && (mPc >= mPre);
      if (mAct) mPc <= wrap ? 0 : mPc + 1;
      if (w && regAddr == 8'h41) mCnt <= {mCnt[63:32], regWdata};
      else if (w && regAddr == 8'h42) mCnt <= {regWdata, mCnt[31:0]};
      else if (wrap) mCnt <= mCnt + longint'(mStep);
      if (w && regAddr == 8'h43) mCmp <= {mCmp[63:32], regWdata};
      if (w && regAddr == 8'h44) mCmp <= {regWdata, mCmp[31:0]};
      if (mAct) mExp <= hit;
      if (w && regAddr == 8'h47 && regWdata[0]) mSt <= 1;
      else if (mAct && hit && mEn) mSt <= 1;
      else if (w && regAddr == 8'h46 && regWdata[0]) mSt <= 0;
      else if (mAct && !hit) mSt <= 0;
      if (w && regAddr == 8'h00) mAct <= regWdata[0];
      if (w && regAddr == 8'h40) begin mPre <= regWdata[11:0]; mStep <= regWdata[23:16]; end
      if (w && regAddr == 8'h45) mEn <= regWdata[0];
    end
  end

  function automatic logic [31:0] expRead(logic [7:0] a);
    case (a)
      8'h00: return {31'b0, mAct};
      8'h40: return {8'b0, mStep[7:0], 4'b0, mPre[11:0]};
      8'h41: return mCnt[31:0];
      8'h42: return mCnt[63:32];
      8'h43: return mCmp[31:0];
      8'h44: return mCmp[63:32];
      8'h45: return {31'b0, mEn};
      8'h46: return {31'b0, mSt};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagOf(logic [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h40: return "R3";
      8'h41, 8'h42, 8'h43, 8'h44: return "R5";
      8'h45, 8'h46: return "R7";
      8'h47: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R6", 64'(timerPending), 64'(mExp));
      check("R7", 64'(irqOut), 64'(mSt && mEn));
      check(tagOf(regAddr), 64'(regRdata), 64'(expRead(regAddr)));
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    regWe = 1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWe = 0;
  endtask

  task automatic rdNow(logic [7:0] a, logic [31:0] exp, string tag);
    regAddr = a; #1;
    check(tag, 64'(regRdata), 64'(exp));
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] snap;
    idle(2); rstN = 1; idle(1);
    // R1 reset values
    check("R1", 64'(timerPending), 0);
    check("R1", 64'(irqOut), 0);
    rdNow(8'h00, 0, "R1"); rdNow(8'h40, 0, "R1");
    rdNow(8'h41, 0, "R1"); rdNow(8'h42, 0, "R1");
    rdNow(8'h43, 32'hFFFF_FFFF, "R1"); rdNow(8'h44, 32'hFFFF_FFFF, "R1");
    rdNow(8'h45, 0, "R1"); rdNow(8'h46, 0, "R1");
    // R11 unmapped
    rdNow(8'h10, 0, "R11"); rdNow(8'h48, 0, "R11");
    wr(8'h10, 32'hFFFF_FFFF);
    rdNow(8'h00, 0, "R11"); rdNow(8'h45, 0, "R11");
    // R3 config padding
    wr(8'h40, 32'hFFFF_FFFF);
    rdNow(8'h40, 32'h00FF_0FFF, "R3");
    // R10 test reads zero
    rdNow(8'h47, 0, "R10");
    // main count: prescale 2, step 5, compare 40
    wr(8'h40, 32'h0005_0002);
    wr(8'h43, 32'd40); wr(8'h44, 0);
    wr(8'h45, 1); wr(8'h00, 1);
    idle(40);
    rdNow(8'h46, 1, "R7");
    check("R6", 64'(timerPending), 1);
    check("R7", 64'(irqOut), 1);
    // R9 collision: clear while expiry keeps setting
    wr(8'h46, 1);
    rdNow(8'h46, 1, "R9");
    check("R9", 64'(irqOut), 1);
    // R8 compare moved ahead
    wr(8'h44, 1);
    check("R8", 64'(timerPending), 1);
    idle(1);
    check("R8", 64'(timerPending), 0);
    rdNow(8'h46, 0, "R8");
    // R7 disabled: raw pending rises, status stays
    wr(8'h45, 0); wr(8'h44, 0); wr(8'h43, 0);
    idle(3);
    check("R7", 64'(timerPending), 1);
    rdNow(8'h46, 0, "R7");
    check("R7", 64'(irqOut), 0);
    // R10 test sets, R9 clear and write-0
    wr(8'h47, 0); rdNow(8'h46, 0, "R10");
    wr(8'h47, 1); rdNow(8'h46, 1, "R10");
    check("R10", 64'(irqOut), 0);
    wr(8'h46, 0); rdNow(8'h46, 1, "R9");
    wr(8'h46, 1); rdNow(8'h46, 0, "R9");
    // R2 inactive holds
    wr(8'h00, 0);
    regAddr = 8'h41; #1; snap = regRdata;
    idle(10);
    rdNow(8'h41, snap, "R2");
    // R4 wrap with prescale 0 step 3
    wr(8'h40, 32'h0003_0000);
    wr(8'h42, 32'hFFFF_FFFF); wr(8'h41, 32'hFFFF_FFFE);
    rdNow(8'h42, 32'hFFFF_FFFF, "R5");
    wr(8'h00, 1);
    idle(2);
    rdNow(8'h42, 0, "R4");
    // R5 write during counting suppresses increment
    wr(8'h41, 32'd100);
    rdNow(8'h41, 32'd100, "R5");
    idle(1);
    rdNow(8'h41, 32'd103, "R4");
    // R6 past compare expires at once
    wr(8'h43, 32'd5);
    idle(1);
    check("R6", 64'(timerPending), 1);
    idle(20);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule